// File: doc/BRIEF.md
# SPI Register Control Port

This block is a four-wire serial slave that lets a host read and write a byte-addressed register map through 16-bit subaddresses. After power-up the device is in its default two-wire control mode and the port ignores all serial traffic. The host moves it into SPI mode by pulsing the latch line low three times. From then on, every low period of the latch line is one frame. The frame starts with a chip-address byte whose lowest bit selects read or write. Two subaddress bytes follow, and after them any number of data bytes.

The register file lives outside the block. The block drives a one-cycle write strobe with the address and data, and a read address whose data comes back on the same cycle. Burst transfers advance the subaddress by one after each complete register word. The six-byte register at 0x4002 is collected in a shadow buffer and committed in one piece. Holes in the map swallow writes and read as 0x00. When the master clock is not valid, writes go through only to 0x4000 and 0x4002. The serial lines are sampled in the `clk_i` domain through synchronizers, so one serial half-period must last at least five `clk_i` cycles.

Top module: `spi_ctl_port`

## Requirements
- R1: After reset `spi_mode_o` is 0 and frames are ignored. It goes to 1 after the third rising edge of `latch_i` and stays at 1 until reset. Frames start only on a falling `latch_i` edge that comes after that point.
- R2: Bits are sampled on rising `sclk_i`, MSB first. Byte 0 carries a 7-bit chip address in bits [7:1], which is not compared, and the R/W bit in bit 0 (1 = read). Bytes 1 and 2 are the subaddress, high byte first. All later bytes are data.
- R3: In a burst, the subaddress advances by 1 after each complete word, whether or not a register exists there, until `latch_i` rises.
- R4: The register at 0x4002 is six bytes, sent MSB first. After the sixth byte, one `wr_en_o` pulse carries all 48 bits on `wr_data_o`. A frame that ends before the sixth byte writes nothing.
- R5: Every other register is one byte. Its write places the byte in `wr_data_o[7:0]` with bits [47:8] zero.
- R6: The holes are 0x4001, 0x4003–0x4007, 0x402E, 0x4032–0x4035, and every subaddress below 0x4000 or above 0x4036. A write to a hole produces no strobe, and a read from a hole returns one byte of 0x00.
- R7: While `mclk_ok_i` is 0, writes reach only 0x4000 and 0x4002.
- R8: In a read frame, `miso_o` changes on falling `sclk_i`, MSB first. The first data bit is valid at the first rising edge after the subaddress. The register at 0x4002 reads out as six bytes, MSB first.
- R9: `miso_o` is 0 during the header bytes, during write frames, and while `latch_i` is high.
- R10: During reset, `wr_en_o`, `miso_o` and `spi_mode_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| mosi_i | input | 1 | Serial data from host |
| latch_i | input | 1 | Frame select, active low; also the mode-entry line |
| mclk_ok_i | input | 1 | Master clock valid |
| miso_o | output | 1 | Serial data to host |
| spi_mode_o | output | 1 | SPI mode entered |
| wr_en_o | output | 1 | Register write strobe, one cycle |
| wr_addr_o | output | 16 | Write subaddress |
| wr_data_o | output | 48 | Write data; single-byte registers use [7:0] |
| rd_addr_o | output | 16 | Read subaddress |
| rd_data_i | input | 48 | Register contents at rd_addr_o, same cycle |

## Verification
The bench sends a write frame before mode entry and checks the mode after only two pulses. A port that counts falling edges or accepts frames early would change the register file or report the mode too soon. It bursts a write across the hole at 0x4001, the six-byte register and the run of holes at 0x4003–0x4007. A port that advanced per byte, or that wrote holes, would put data at the wrong addresses or produce extra strobes. It cuts a wide write short and reads the old value back, which catches partial commits. It also checks the last mapped address and the first address past it, and the two addresses that stay writable while the master clock is invalid.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int unsigned SUB_W = 16;
  localparam logic [SUB_W-1:0] MAP_FIRST = 16'h4000;
  localparam logic [SUB_W-1:0] MAP_LAST  = 16'h4036;
  localparam logic [SUB_W-1:0] WIDE_ADDR = 16'h4002;

  typedef enum logic [1:0] {PH_CHIP, PH_ADDR_HI, PH_ADDR_LO, PH_DATA} phase_e;

  function automatic logic addr_is_hole(input logic [SUB_W-1:0] a);
    return (a < MAP_FIRST) || (a > MAP_LAST) || (a == 16'h4001) ||
           ((a >= 16'h4003) && (a <= 16'h4007)) || (a == 16'h402E) ||
           ((a >= 16'h4032) && (a <= 16'h4035));
  endfunction

  // writable without a valid master clock
  function automatic logic addr_ungated(input logic [SUB_W-1:0] a);
    return (a == MAP_FIRST) || (a == WIDE_ADDR);
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_mode_sel.sv
module spi_mode_sel #(
  parameter int unsigned PULSES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic latch_s_i,
  output logic mode_o
);
  localparam int unsigned CNT_W = $clog2(PULSES + 1);

  logic             latch_p_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_p_q <= 1'b1;
      cnt_q     <= '0;
      mode_q    <= 1'b0;
    end else begin
      latch_p_q <= latch_s_i;
      if (!mode_q && latch_s_i && !latch_p_q) begin
        if (cnt_q == CNT_W'(PULSES - 1)) mode_q <= 1'b1;
        else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mode_o = mode_q;

  assert_mode_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |=> mode_q);
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_ctl_pkg::*;
#(
  parameter int unsigned WIDE_BYTES = 6,
  localparam int unsigned DW    = 8 * WIDE_BYTES,
  localparam int unsigned IDX_W = $clog2(WIDE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_s_i,
  input  logic             mosi_s_i,
  input  logic             latch_s_i,
  input  logic             mode_i,
  input  logic             mclk_ok_i,
  output logic             wr_en_o,
  output logic [SUB_W-1:0] wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic [SUB_W-1:0] addr_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             clear_o
);
  logic             sclk_p_q, latch_p_q, in_frame_q, rw_q;
  phase_e           phase_q;
  logic [2:0]       bit_cnt_q;
  logic [6:0]       sh_q;
  logic [SUB_W-1:0] addr_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-9:0]    shadow_q;
  logic             wr_en_q, ld_q;
  logic [SUB_W-1:0] wr_addr_q;
  logic [DW-1:0]    wr_data_q;

  logic       sclk_rise, sclk_fall, latch_rise, latch_fall;
  logic [7:0] nxt_byte;
  logic       word_last, wr_ok;
  logic [DW-1:0] wide_cat;

  assign sclk_rise  = sclk_s_i && !sclk_p_q;
  assign sclk_fall  = !sclk_s_i && sclk_p_q;
  assign latch_rise = latch_s_i && !latch_p_q;
  assign latch_fall = !latch_s_i && latch_p_q;
  assign nxt_byte   = {sh_q, mosi_s_i};
  assign wide_cat   = {shadow_q, nxt_byte};
  assign word_last  = (addr_q != WIDE_ADDR) || (idx_q == IDX_W'(WIDE_BYTES - 1));
  assign wr_ok      = !addr_is_hole(addr_q) && (mclk_ok_i || addr_ungated(addr_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_p_q   <= 1'b0;
      latch_p_q  <= 1'b1;
      in_frame_q <= 1'b0;
      rw_q       <= 1'b0;
      phase_q    <= PH_CHIP;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      addr_q     <= '0;
      idx_q      <= '0;
      shadow_q   <= '0;
      wr_en_q    <= 1'b0;
      ld_q       <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      sclk_p_q  <= sclk_s_i;
      latch_p_q <= latch_s_i;
      wr_en_q   <= 1'b0;
      ld_q      <= 1'b0;
      if (latch_rise) begin
        in_frame_q <= 1'b0;
        phase_q    <= PH_CHIP;
        bit_cnt_q  <= '0;
        idx_q      <= '0;
      end else if (latch_fall && mode_i) begin
        in_frame_q <= 1'b1;
        phase_q    <= PH_CHIP;
        bit_cnt_q  <= '0;
        idx_q      <= '0;
      end else if (in_frame_q && sclk_rise) begin
        sh_q      <= nxt_byte[6:0];
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == 3'd7) begin
          unique case (phase_q)
            PH_CHIP: begin
              rw_q    <= nxt_byte[0];
              phase_q <= PH_ADDR_HI;
            end
            PH_ADDR_HI: begin
              addr_q[15:8] <= nxt_byte;
              phase_q      <= PH_ADDR_LO;
            end
            PH_ADDR_LO: begin
              addr_q[7:0] <= nxt_byte;
              idx_q       <= '0;
              phase_q     <= PH_DATA;
              ld_q        <= rw_q;
            end
            default: begin
              if (word_last) begin
                addr_q <= addr_q + 1'b1;
                idx_q  <= '0;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
              if (rw_q) begin
                ld_q <= 1'b1;
              end else begin
                shadow_q <= wide_cat[DW-9:0];
                if (word_last) begin
                  wr_en_q   <= wr_ok;
                  wr_addr_q <= addr_q;
                  wr_data_q <= (addr_q == WIDE_ADDR) ? wide_cat : {{(DW-8){1'b0}}, nxt_byte};
                end
              end
            end
          endcase
        end
      end
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign addr_o    = addr_q;
  assign idx_o     = idx_q;
  assign load_o    = ld_q;
  assign shift_o   = sclk_fall && in_frame_q;
  assign clear_o   = latch_rise;

  assert_wr_in_write_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !rw_q);
  assert_wr_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  assert_narrow_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o != WIDE_ADDR) |-> (wr_data_o[DW-1:8] == '0));
  assert_no_hole_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !addr_is_hole(wr_addr_o));
  assert_mclk_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !$past(mclk_ok_i)) |-> addr_ungated(wr_addr_o));
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_ctl_pkg::*;
#(
  parameter int unsigned WIDE_BYTES = 6,
  localparam int unsigned DW    = 8 * WIDE_BYTES,
  localparam int unsigned IDX_W = $clog2(WIDE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SUB_W-1:0] addr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    rd_data_i,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             clear_i,
  output logic             miso_o
);
  logic [7:0] lane [WIDE_BYTES];
  logic [7:0] sel_byte;
  logic [7:0] tx_q;
  logic       miso_q;

  for (genvar g = 0; g < WIDE_BYTES; g++) begin : g_lane
    assign lane[g] = rd_data_i[8*(WIDE_BYTES-1-g) +: 8];
  end

  always_comb begin
    sel_byte = rd_data_i[7:0];
    if (addr_is_hole(addr_i)) begin
      sel_byte = 8'h00;
    end else if (addr_i == WIDE_ADDR) begin
      sel_byte = 8'h00;
      for (int k = 0; k < WIDE_BYTES; k++)
        if (idx_i == IDX_W'(k)) sel_byte = lane[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else if (clear_i) begin
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else if (load_i) begin
      tx_q <= sel_byte;
    end else if (shift_i) begin
      miso_q <= tx_q[7];
      tx_q   <= {tx_q[6:0], 1'b0};
    end
  end

  assign miso_o = miso_q;
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter int unsigned WIDE_BYTES  = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MODE_PULSES = 3,
  localparam int unsigned DW    = 8 * WIDE_BYTES,
  localparam int unsigned IDX_W = $clog2(WIDE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             mosi_i,
  input  logic             latch_i,
  input  logic             mclk_ok_i,
  output logic             miso_o,
  output logic             spi_mode_o,
  output logic             wr_en_o,
  output logic [SUB_W-1:0] wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic [SUB_W-1:0] rd_addr_o,
  input  logic [DW-1:0]    rd_data_i
);
  logic [2:0]       pins_s;
  logic             sclk_s, mosi_s, latch_s;
  logic             mode;
  logic [IDX_W-1:0] idx;
  logic             load, shift, clear;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({latch_i, mosi_i, sclk_i}),
    .q_o   (pins_s)
  );
  assign latch_s = pins_s[2];
  assign mosi_s  = pins_s[1];
  assign sclk_s  = pins_s[0];

  spi_mode_sel #(.PULSES(MODE_PULSES)) u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .latch_s_i(latch_s),
    .mode_o   (mode)
  );

  spi_frame_ctrl #(.WIDE_BYTES(WIDE_BYTES)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (sclk_s),
    .mosi_s_i (mosi_s),
    .latch_s_i(latch_s),
    .mode_i   (mode),
    .mclk_ok_i(mclk_ok_i),
    .wr_en_o  (wr_en_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o),
    .addr_o   (rd_addr_o),
    .idx_o    (idx),
    .load_o   (load),
    .shift_o  (shift),
    .clear_o  (clear)
  );

  spi_tx_shift #(.WIDE_BYTES(WIDE_BYTES)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (rd_addr_o),
    .idx_i    (idx),
    .rd_data_i(rd_data_i),
    .load_i   (load),
    .shift_i  (shift),
    .clear_i  (clear),
    .miso_o   (miso_o)
  );

  assign spi_mode_o = mode;

  assert_no_write_before_mode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_mode_o |-> !wr_en_o);
  assert_miso_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_s && $past(latch_s)) |-> !miso_o);
endmodule

// File: tb/spi_ctl_port_tb.sv
module spi_ctl_port_tb_top;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, latch = 1'b1, mclk_ok = 1'b1;
  logic miso, spi_mode, wr_en;
  logic [15:0] wr_addr, rd_addr;
  logic [47:0] wr_data, rd_data;

  always #4 clk = ~clk;

  spi_ctl_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .mosi_i(mosi), .latch_i(latch),
    .mclk_ok_i(mclk_ok), .miso_o(miso), .spi_mode_o(spi_mode), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  // register file model
  logic [7:0]  mem [64];
  logic [47:0] wide_q = '0;
  logic [15:0] log_a [16];
  logic [47:0] log_d [16];
  int wr_cnt = 0;
  initial for (int i = 0; i < 64; i++) mem[i] = 8'h00;
  assign rd_data = (rd_addr == 16'h4002) ? wide_q : {40'b0, mem[rd_addr[5:0]]};
  always @(posedge clk) if (wr_en) begin
    log_a[wr_cnt[3:0]] = wr_addr;
    log_d[wr_cnt[3:0]] = wr_data;
    wr_cnt = wr_cnt + 1;
    if (wr_addr == 16'h4002) wide_q = wr_data;
    else mem[wr_addr[5:0]] = wr_data[7:0];
  end

  int checks = 0, errors = 0;
  logic [7:0] ref_mem [64];
  logic [15:0] hdr_rx;

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      tick(H);
      sclk = 1'b1;
      rx[i] = miso;
      tick(H);
      sclk = 1'b0;
    end
  endtask

  task automatic open_frame(input logic rw, input logic [15:0] a, input logic [6:0] chip);
    logic [7:0] r0, r1, r2;
    latch = 1'b0;
    tick(H);
    xfer({chip, rw}, r0);
    xfer(a[15:8], r1);
    xfer(a[7:0], r2);
    hdr_rx = {r1, r2};
  endtask

  task automatic close_frame();
    tick(H);
    latch = 1'b1;
    tick(3 * H);
  endtask

  task automatic wr_byte(input logic [7:0] b);
    logic [7:0] r;
    xfer(b, r);
  endtask

  task automatic rd_byte(output logic [7:0] b);
    xfer(8'h00, b);
  endtask

  function automatic logic tb_hole(input logic [15:0] a);
    return a < 16'h4000 || a > 16'h4036 || a == 16'h4001 || (a >= 16'h4003 && a <= 16'h4007) ||
           a == 16'h402E || (a >= 16'h4032 && a <= 16'h4035);
  endfunction

  // {addr, data, mclk_ok, expect_write}
  localparam logic [25:0] VEC [9] = '{
    {16'h4000, 8'h5A, 1'b1, 1'b1},
    {16'h4010, 8'h3C, 1'b1, 1'b1},
    {16'h4036, 8'h81, 1'b1, 1'b1},
    {16'h4001, 8'hFF, 1'b1, 1'b0},
    {16'h402E, 8'h77, 1'b1, 1'b0},
    {16'h4033, 8'h11, 1'b1, 1'b0},
    {16'h4037, 8'h22, 1'b1, 1'b0},
    {16'h4010, 8'h99, 1'b0, 1'b0},
    {16'h4000, 8'hA5, 1'b0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int base;
    logic [7:0] b;
    for (int i = 0; i < 64; i++) ref_mem[i] = 8'h00;
    tick(3);
    check(!spi_mode && !wr_en && !miso, "R10", "reset outputs", {spi_mode, wr_en, miso}, 0);
    rst_ni = 1'b1;
    tick(4);

    // R1: frame before mode entry is the first pulse and writes nothing
    open_frame(1'b0, 16'h4010, 7'h38);
    wr_byte(8'h66);
    close_frame();
    check(wr_cnt == 0, "R1", "write before mode", wr_cnt, 0);
    check(!spi_mode, "R1", "mode after 1 pulse", spi_mode, 0);
    latch = 1'b0; tick(H); latch = 1'b1; tick(H);
    check(!spi_mode, "R1", "mode after 2 pulses", spi_mode, 0);
    latch = 1'b0; tick(H); latch = 1'b1; tick(H);
    check(spi_mode, "R1", "mode after 3 pulses", spi_mode, 1);

    // vector table: single-byte writes, holes, gating (R2 R5 R6 R7)
    for (int v = 0; v < 9; v++) begin
      logic [15:0] a;
      logic [7:0] d;
      logic ex;
      a = VEC[v][25:10];
      d = VEC[v][9:2];
      ex = VEC[v][0];
      mclk_ok = VEC[v][1];
      base = wr_cnt;
      open_frame(1'b0, a, 7'(v * 13));
      wr_byte(d);
      close_frame();
      check(wr_cnt == base + int'(ex), "R6/R7", "write strobe count", wr_cnt - base, ex);
      if (ex) begin
        ref_mem[a[5:0]] = d;
        check(log_a[base[3:0]] == a && log_d[base[3:0]] == {40'b0, d}, "R5", "narrow write",
              {log_a[base[3:0]], log_d[base[3:0]]}, {a, 40'b0, d});
      end
      mclk_ok = 1'b1;
      open_frame(1'b1, a, 7'h7F);
      rd_byte(b);
      close_frame();
      check(b == (tb_hole(a) ? 8'h00 : ref_mem[a[5:0]]), "R6", "read back", b,
            tb_hole(a) ? 8'h00 : ref_mem[a[5:0]]);
    end

    // R3 R4 R6: burst write across holes and the wide register
    base = wr_cnt;
    open_frame(1'b0, 16'h4000, 7'h00);
    wr_byte(8'h11); wr_byte(8'h22);
    wr_byte(8'hA1); wr_byte(8'hA2); wr_byte(8'hA3);
    wr_byte(8'hA4); wr_byte(8'hA5); wr_byte(8'hA6);
    wr_byte(8'h33); wr_byte(8'h44); wr_byte(8'h45); wr_byte(8'h46); wr_byte(8'h47);
    wr_byte(8'h55);
    close_frame();
    check(wr_cnt == base + 3, "R3", "burst strobe count", wr_cnt - base, 3);
    check(log_a[base[3:0]] == 16'h4000 && log_d[base[3:0]] == 48'h11, "R3", "burst word 0",
          log_d[base[3:0]], 48'h11);
    check(log_a[4'(base + 1)] == 16'h4002 && log_d[4'(base + 1)] == 48'hA1A2A3A4A5A6, "R4",
          "wide commit", log_d[4'(base + 1)], 48'hA1A2A3A4A5A6);
    check(log_a[4'(base + 2)] == 16'h4008 && log_d[4'(base + 2)] == 48'h55, "R3", "burst after holes",
          log_a[4'(base + 2)], 16'h4008);

    // R4: truncated wide write is dropped
    base = wr_cnt;
    open_frame(1'b0, 16'h4002, 7'h00);
    wr_byte(8'hEE); wr_byte(8'hEE); wr_byte(8'hEE);
    close_frame();
    check(wr_cnt == base, "R4", "partial wide write", wr_cnt - base, 0);

    // R8 R9: burst read of 0x4000..0x4003
    open_frame(1'b1, 16'h4000, 7'h2A);
    check(hdr_rx == 16'h0000, "R9", "miso during header", hdr_rx, 0);
    rd_byte(b); check(b == 8'h11, "R8", "read 0x4000", b, 8'h11);
    rd_byte(b); check(b == 8'h00, "R6", "read hole 0x4001", b, 8'h00);
    for (int k = 0; k < 6; k++) begin
      rd_byte(b);
      check(b == 8'(8'hA1 + k), "R8", "wide read byte", b, 8'(8'hA1 + k));
    end
    rd_byte(b); check(b == 8'h00, "R6", "read hole 0x4003", b, 8'h00);
    close_frame();
    check(!miso, "R9", "miso after frame", miso, 0);

    // R6: end of map and first address past it
    open_frame(1'b1, 16'h4036, 7'h01);
    rd_byte(b); check(b == 8'h81, "R8", "read 0x4036", b, 8'h81);
    rd_byte(b); check(b == 8'h00, "R6", "read 0x4037", b, 8'h00);
    close_frame();

    // R7: wide register writable without master clock
    mclk_ok = 1'b0;
    base = wr_cnt;
    open_frame(1'b0, 16'h4002, 7'h00);
    for (int k = 0; k < 6; k++) wr_byte(8'(8'hC0 + k));
    wr_byte(8'h5C);
    close_frame();
    mclk_ok = 1'b1;
    check(wr_cnt == base + 1 && log_d[base[3:0]] == 48'hC0C1C2C3C4C5, "R7", "wide write gated clk",
          log_d[base[3:0]], 48'hC0C1C2C3C4C5);

    // R1 R10: reset returns to two-wire mode
    rst_ni = 1'b0;
    tick(2);
    check(!spi_mode && !miso && !wr_en, "R10", "reset again", {spi_mode, miso, wr_en}, 0);
    rst_ni = 1'b1;
    tick(2);
    check(!spi_mode, "R1", "mode cleared by reset", spi_mode, 0);
    finish_run();
  end
endmodule